// File: doc/BRIEF.md
# Single-Wire Bus Host Slot Timer

This block is the host side of an open-drain, single-wire serial bus with an external pullup. A local controller asks for one operation at a time: a bus reset with presence detection, a write of a zero bit, a write of a one bit, or a read of one bit. The block pulls the line low through an open-drain enable, samples the line through a synchronizer, and returns the result together with a one-cycle completion strobe.

Each operation runs at standard or overdrive speed. The speed is taken from an input when the command is accepted and then stays fixed until the operation ends. All pulse widths, sample points and slot lengths are cycle counts derived from the `CLK_MHZ` parameter. The nominal times (µs, standard / overdrive) are: reset low 500 / 60; released window after reset 480 / 48; presence sample 70 / 8 after release; write-zero low 65 / 8; write-one low 6 / 1; read low 5 / 1; read sample 12 / 2 after the falling edge; and a write or read slot of 70 / 11 plus 5 µs of recovery.

Top module: `sw_bus_host`

## Requirements
- R1: While `rst_n` is low and after it is released with no command, `line_drive_low`, `busy` and `done` are all 0.
- R2: Command code 0 at standard speed (`cmd_fast`=0) drives the line low for 500 µs and raises `done` 980 µs after the accepting edge. `rx_bit` is 1 (target present) exactly when the line is low at the point 70 µs after release.
- R3: Command code 0 at overdrive speed (`cmd_fast`=1) drives the line low for 60 µs, samples presence 8 µs after release and raises `done` 108 µs after the accepting edge.
- R4: Command code 1 (write zero) drives the line low for 65 µs (standard) or 8 µs (overdrive). `done` rises 75 µs (standard) or 16 µs (overdrive) after the accepting edge.
- R5: Command code 2 (write one) drives the line low for 6 µs (standard) or 1 µs (overdrive), with the same slot length as R4.
- R6: Command code 3 (read) drives the line low for 5 µs (standard) or 1 µs (overdrive), with the same slot length as R4. `rx_bit` is the line level sampled 12 µs (standard) or 2 µs (overdrive) after the falling edge: 1 for high, 0 for low.
- R7: `done` lasts exactly one cycle. `busy` is 1 from the cycle after the accepting edge until `done` rises, and it is 0 while `done` is high.
- R8: A command presented while `busy` is 1 is ignored. It neither starts a second operation nor changes the running operation's low time or slot length.
- R9: A change on `cmd_fast` or `cmd_op` after the accepting edge does not change the timing of the running operation.
- R10: A target low pulse that ends before the presence sample point gives `rx_bit` 0 (absent).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency `CLK_MHZ` MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 2 | 0 reset/presence, 1 write zero, 2 write one, 3 read |
| cmd_fast | input | 1 | 0 standard speed, 1 overdrive speed |
| line_in | input | 1 | Bus line level as seen at the pad |
| line_drive_low | output | 1 | Open-drain enable; 1 pulls the bus low |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| rx_bit | output | 1 | Presence flag or read bit, valid with `done` |

## Verification
Every operation runs at both speeds while the bench times the low pulse and the cycles to `done`. This separates the timing entries of the two speed tables and those of the four command codes. Presence runs three target patterns: a pulse covering the sample point, no pulse, and a pulse that ends just before the sample point. Together they place the sample instant inside the released window. Reads run with a silent target and with a target holding the line past the sample point, which shows that the bit comes from the sample and not from the host's own pulse. A burst of conflicting commands and a speed flip during a running slot show that the latched job controls the timing.

// File: rtl/sw_bus_host_pkg.sv
package sw_bus_host_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WR0   = 2'd1,
    OP_WR1   = 2'd2,
    OP_READ  = 2'd3
  } sw_op_e;

  typedef struct packed {
    sw_op_e op;
    logic   fast;
  } sw_job_t;

  // Nominal times in microseconds: standard / overdrive
  localparam int unsigned RST_LOW_STD  = 500;
  localparam int unsigned RST_LOW_OD   = 60;
  localparam int unsigned RST_REL_STD  = 480;
  localparam int unsigned RST_REL_OD   = 48;
  localparam int unsigned PRES_SMP_STD = 70;
  localparam int unsigned PRES_SMP_OD  = 8;
  localparam int unsigned W0_LOW_STD   = 65;
  localparam int unsigned W0_LOW_OD    = 8;
  localparam int unsigned W1_LOW_STD   = 6;
  localparam int unsigned W1_LOW_OD    = 1;
  localparam int unsigned RD_LOW_STD   = 5;
  localparam int unsigned RD_LOW_OD    = 1;
  localparam int unsigned RD_SMP_STD   = 12;
  localparam int unsigned RD_SMP_OD    = 2;
  localparam int unsigned SLOT_STD     = 70;
  localparam int unsigned SLOT_OD      = 11;
  localparam int unsigned RECOVERY     = 5;

  localparam int unsigned LONGEST_US = RST_LOW_STD + RST_REL_STD;

endpackage

// File: rtl/sw_line_sync.sv
module sw_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b1;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/sw_slot_timing.sv
module sw_slot_timing
  import sw_bus_host_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 100,
  parameter int unsigned CNT_W   = 17
) (
  input  sw_job_t          job,
  output logic [CNT_W-1:0] low_cyc,
  output logic [CNT_W-1:0] smp_tick,
  output logic [CNT_W-1:0] end_tick
);

  localparam int unsigned C_RST_LOW_S = RST_LOW_STD * CLK_MHZ;
  localparam int unsigned C_RST_LOW_O = RST_LOW_OD * CLK_MHZ;
  localparam int unsigned C_RST_END_S = (RST_LOW_STD + RST_REL_STD) * CLK_MHZ - 1;
  localparam int unsigned C_RST_END_O = (RST_LOW_OD + RST_REL_OD) * CLK_MHZ - 1;
  localparam int unsigned C_PRES_S    = (RST_LOW_STD + PRES_SMP_STD) * CLK_MHZ;
  localparam int unsigned C_PRES_O    = (RST_LOW_OD + PRES_SMP_OD) * CLK_MHZ;
  localparam int unsigned C_SLOT_END_S = (SLOT_STD + RECOVERY) * CLK_MHZ - 1;
  localparam int unsigned C_SLOT_END_O = (SLOT_OD + RECOVERY) * CLK_MHZ - 1;

  always_comb begin
    smp_tick = '0;
    if (job.op == OP_RESET) begin
      low_cyc  = CNT_W'(job.fast ? C_RST_LOW_O : C_RST_LOW_S);
      smp_tick = CNT_W'(job.fast ? C_PRES_O : C_PRES_S);
      end_tick = CNT_W'(job.fast ? C_RST_END_O : C_RST_END_S);
    end else begin
      end_tick = CNT_W'(job.fast ? C_SLOT_END_O : C_SLOT_END_S);
      unique case (job.op)
        OP_WR0:  low_cyc = CNT_W'((job.fast ? W0_LOW_OD : W0_LOW_STD) * CLK_MHZ);
        OP_WR1:  low_cyc = CNT_W'((job.fast ? W1_LOW_OD : W1_LOW_STD) * CLK_MHZ);
        default: begin
          low_cyc  = CNT_W'((job.fast ? RD_LOW_OD : RD_LOW_STD) * CLK_MHZ);
          smp_tick = CNT_W'((job.fast ? RD_SMP_OD : RD_SMP_STD) * CLK_MHZ);
        end
      endcase
    end
  end

endmodule

// File: rtl/sw_slot_seq.sv
module sw_slot_seq
  import sw_bus_host_pkg::*;
#(
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic             cmd_fast,
  input  logic             line_s,
  input  logic [CNT_W-1:0] low_cyc,
  input  logic [CNT_W-1:0] smp_tick,
  input  logic [CNT_W-1:0] end_tick,
  output sw_job_t          job,
  output logic             drive_low,
  output logic             busy,
  output logic             done,
  output logic             rx_bit
);

  typedef enum logic {ST_IDLE, ST_RUN} st_e;

  st_e              st_q, st_d;
  logic [CNT_W-1:0] tick_q, tick_d;
  sw_job_t          job_q, job_d;
  logic             drv_q, drv_d;
  logic             smp_q, smp_d;
  logic             done_q, done_d;
  logic             bit_q, bit_d;
  logic             tick_en, job_en, smp_en, bit_en;
  logic [CNT_W-1:0] tick_inc;

  assign tick_inc = tick_q + 1'b1;

  always_comb begin
    st_d    = st_q;
    tick_d  = tick_q;
    job_d   = job_q;
    smp_d   = smp_q;
    bit_d   = bit_q;
    drv_d   = 1'b0;
    done_d  = 1'b0;
    tick_en = 1'b0;
    job_en  = 1'b0;
    smp_en  = 1'b0;
    bit_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          st_d    = ST_RUN;
          tick_d  = '0;
          tick_en = 1'b1;
          job_d   = '{op: sw_op_e'(cmd_op), fast: cmd_fast};
          job_en  = 1'b1;
          drv_d   = 1'b1;
        end
      end
      default: begin
        tick_d  = tick_inc;
        tick_en = 1'b1;
        drv_d   = (tick_inc < low_cyc);
        if (tick_q == smp_tick) begin
          smp_d  = line_s;
          smp_en = 1'b1;
        end
        if (tick_q == end_tick) begin
          st_d   = ST_IDLE;
          drv_d  = 1'b0;
          done_d = 1'b1;
          bit_en = 1'b1;
          bit_d  = (job_q.op == OP_RESET) ? ~smp_q : smp_q;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      drv_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      drv_q  <= drv_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tick_q <= '0;
    else if (tick_en) tick_q <= tick_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      job_q <= '{op: OP_RESET, fast: 1'b0};
    else if (job_en) job_q <= job_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      smp_q <= 1'b1;
    else if (smp_en) smp_q <= smp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bit_q <= 1'b0;
    else if (bit_en) bit_q <= bit_d;
  end

  assign job       = job_q;
  assign drive_low = drv_q;
  assign busy      = (st_q == ST_RUN);
  assign done      = done_q;
  assign rx_bit    = bit_q;

endmodule

// File: rtl/sw_bus_host.sv
module sw_bus_host
  import sw_bus_host_pkg::*;
#(
  parameter int unsigned CLK_MHZ     = 100,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_fast,
  input  logic       line_in,
  output logic       line_drive_low,
  output logic       busy,
  output logic       done,
  output logic       rx_bit
);

  localparam int unsigned MAX_CYC = LONGEST_US * CLK_MHZ;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic             line_s;
  sw_job_t          job;
  logic [CNT_W-1:0] low_cyc, smp_tick, end_tick;

  sw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (line_in),
    .d_out (line_s)
  );

  sw_slot_timing #(.CLK_MHZ(CLK_MHZ), .CNT_W(CNT_W)) u_timing (
    .job      (job),
    .low_cyc  (low_cyc),
    .smp_tick (smp_tick),
    .end_tick (end_tick)
  );

  sw_slot_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_fast  (cmd_fast),
    .line_s    (line_s),
    .low_cyc   (low_cyc),
    .smp_tick  (smp_tick),
    .end_tick  (end_tick),
    .job       (job),
    .drive_low (line_drive_low),
    .busy      (busy),
    .done      (done),
    .rx_bit    (rx_bit)
  );

endmodule

// File: rtl/sw_bus_host_chk.sv
module sw_bus_host_chk (
  input logic clk,
  input logic rst_n,
  input logic line_drive_low,
  input logic busy,
  input logic done
);

  // R7: completion strobe is a single cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: busy only falls together with done
  a_r7_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R7: not busy while the strobe is high
  a_r7_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8: the line is only pulled while an operation runs
  a_r8_drive_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    line_drive_low |-> busy);

  // R8: a low pulse only begins when a new operation starts from idle
  a_r8_one_pulse_per_op: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_drive_low) |-> $rose(busy));

endmodule

bind sw_bus_host sw_bus_host_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .line_drive_low (line_drive_low),
  .busy           (busy),
  .done           (done)
);

// File: tb/sw_bus_host_test.sv
`timescale 1ns/1ps
module sw_bus_host_test;

  localparam int M = 4;  // clock cycles per microsecond seen by the design

  logic       clk;
  logic       rst_n;
  logic       cmd_valid;
  logic [1:0] cmd_op;
  logic       cmd_fast;
  logic       tgt_low;
  logic       line;
  logic       line_drive_low, busy, done, rx_bit;

  int tests_run = 0;
  int tests_fail = 0;

  assign line = !(line_drive_low || tgt_low);

  sw_bus_host #(.CLK_MHZ(M), .SYNC_STAGES(2)) uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid      (cmd_valid),
    .cmd_op         (cmd_op),
    .cmd_fast       (cmd_fast),
    .line_in        (line),
    .line_drive_low (line_drive_low),
    .busy           (busy),
    .done           (done),
    .rx_bit         (rx_bit)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests_run++;
    if (!ok) begin
      tests_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Runs one operation; the target pulls low from tick t_start for t_len cycles.
  // With disturb set, conflicting commands and a speed flip arrive mid-operation.
  task automatic run_op(input logic [1:0] op, input logic fast,
                        input int t_start, input int t_len, input bit disturb,
                        output int low_cnt, output int to_done, output logic bit_out,
                        output int busy_err);
    @(negedge clk);
    cmd_op = op; cmd_fast = fast; cmd_valid = 1'b1;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    low_cnt = 0; to_done = 0; busy_err = 0; bit_out = 1'b0;
    fork
      begin
        forever begin
          @(negedge clk);
          to_done++;
          if (disturb && to_done == 10) begin
            cmd_valid = 1'b1; cmd_op = 2'd1; cmd_fast = ~fast;
          end
          if (disturb && to_done == 20) cmd_valid = 1'b0;
          if (line_drive_low) low_cnt++;
          if (done) begin
            bit_out = rx_bit;
            if (busy) busy_err++;
            break;
          end
          if (!busy) busy_err++;
        end
      end
      begin
        if (t_len > 0) begin
          repeat (t_start + 1) @(negedge clk);
          tgt_low = 1'b1;
          repeat (t_len) @(negedge clk);
          tgt_low = 1'b0;
        end
      end
    join
    @(negedge clk);
    chk(!done, "R7 done width", done, 0);
    cmd_fast = 1'b0;
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_fast = 1'b0; tgt_low = 1'b0;
    repeat (3) @(negedge clk);
    chk(!line_drive_low && !busy && !done, "R1 in reset", {line_drive_low, busy, done}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!line_drive_low && !busy && !done, "R1 after reset", {line_drive_low, busy, done}, 0);
  endtask

  task automatic t_presence(input logic fast, input int mode, input string tag);
    int low_us, rel_us, smp_us, lc, td, be, st, ln;
    logic b, exp_b;
    low_us = fast ? 60 : 500;
    rel_us = fast ? 48 : 480;
    smp_us = fast ? 8 : 70;
    if (mode == 1) begin       // pulse covering the sample point
      st = (low_us + smp_us / 2) * M; ln = smp_us * M; exp_b = 1'b1;
    end else if (mode == 2) begin  // pulse ending before the sample point
      st = low_us * M + 4; ln = (smp_us * M) - 4 * M - 4; exp_b = 1'b0;
    end else begin
      st = 0; ln = 0; exp_b = 1'b0;
    end
    run_op(2'd0, fast, st, ln, 1'b0, lc, td, b, be);
    chk(lc == low_us * M, {tag, " reset low"}, lc, low_us * M);
    chk(td == (low_us + rel_us) * M + 1, {tag, " reset length"}, td, (low_us + rel_us) * M + 1);
    chk(b == exp_b, {tag, " presence flag"}, b, exp_b);
    chk(be == 0, "R7 busy span", be, 0);
  endtask

  task automatic t_write(input logic one, input logic fast, input string tag);
    int lo, lc, td, be;
    logic b;
    lo = one ? (fast ? 1 : 6) : (fast ? 8 : 65);
    run_op(one ? 2'd2 : 2'd1, fast, 0, 0, 1'b0, lc, td, b, be);
    chk(lc == lo * M, {tag, " low time"}, lc, lo * M);
    chk(td == (fast ? 16 : 75) * M + 1, {tag, " slot length"}, td, (fast ? 16 : 75) * M + 1);
  endtask

  task automatic t_read(input logic fast, input logic tgt_zero, input string tag);
    int lc, td, be, hold;
    logic b;
    hold = (fast ? 3 : 15) * M;
    run_op(2'd3, fast, 0, tgt_zero ? hold : 0, 1'b0, lc, td, b, be);
    chk(lc == (fast ? 1 : 5) * M, {tag, " read low"}, lc, (fast ? 1 : 5) * M);
    chk(td == (fast ? 16 : 75) * M + 1, {tag, " read slot"}, td, (fast ? 16 : 75) * M + 1);
    chk(b == !tgt_zero, {tag, " read bit"}, b, !tgt_zero);
  endtask

  task automatic t_busy_ignore();
    int lc, td, be, extra;
    logic b;
    run_op(2'd3, 1'b0, 0, 0, 1'b1, lc, td, b, be);
    chk(lc == 5 * M, "R8 R9 low kept", lc, 5 * M);
    chk(td == 75 * M + 1, "R8 R9 slot kept", td, 75 * M + 1);
    chk(b == 1'b1, "R8 read bit kept", b, 1);
    extra = 0;
    repeat (20) begin
      @(negedge clk);
      if (busy || line_drive_low) extra++;
    end
    chk(extra == 0, "R8 no second op", extra, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests_run++;
    tests_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_presence(1'b0, 1, "R2");
    t_presence(1'b0, 0, "R2 absent");
    t_presence(1'b0, 2, "R10");
    t_presence(1'b1, 1, "R3");
    t_presence(1'b1, 2, "R3 R10");
    t_write(1'b0, 1'b0, "R4 std");
    t_write(1'b0, 1'b1, "R4 od");
    t_write(1'b1, 1'b0, "R5 std");
    t_write(1'b1, 1'b1, "R5 od");
    t_read(1'b0, 1'b0, "R6 std one");
    t_read(1'b0, 1'b1, "R6 std zero");
    t_read(1'b1, 1'b0, "R6 od one");
    t_read(1'b1, 1'b1, "R6 od zero");
    t_busy_ignore();
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_fail);
    $finish;
  end

endmodule